// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a small debug register file that a host reaches one serial scan at a time. Three strobes from an external test-access-port controller drive it: capture, shift and update, together with a serial input, a serial output and the test clock. Each scan moves a 38-bit frame. Bits 31:0 of the frame carry a data word, bits 36:32 carry a register address, and bit 37 carries a write flag. The frame is shifted least significant bit first. The host writes a register by scanning in a frame whose write flag is set. A read takes two scans: the first scan names the address, and the value comes back during the next scan.

The register file holds the following registers:
- a debug control register and a debug status register;
- an optional vector-catch register;
- two watch units, each with six 32-bit value and mask words;
- a mailbox that carries one word in each direction between the host and the core.

All registers are driven to the core as parallel outputs. The mailbox has a control word with two flags. The host-readable flag is set when the core posts a word, and it is cleared when the host reads the data address. Because that read clears the flag, the host should name the side-effect-free control address as the follow-up address in the second scan of a read.

Top module: `dbgscan_top`

## Requirements
- R1: While `shift_en` is high, the frame moves one bit toward bit 0 on every clock. `tdi` enters at bit 37, and `tdo` always shows bit 0. After 38 shifts, bits 31:0 hold the data, bits 36:32 the address and bit 37 the write flag.
- R2: When `capture_en` is high, the frame is loaded with the pending read word in bits 31:0 and with zeros in bits 37:32.
- R3: An `update_en` cycle with bit 37 = 1 writes the data field into the addressed register, and the new value appears on the parallel outputs after that edge. Without `update_en`, no register changes. Watch word k (unit 0 at addresses 0x08..0x0D, unit 1 at addresses 0x10..0x15, ordered as address value, address mask, data value, data mask, control value, control mask) appears on `watch_o[32k+31:32k]`, where k = unit*6 + index.
- R4: An `update_en` cycle with bit 37 = 0 latches the value of the addressed register as the pending read word. That word is shifted out during the next scan.
- R5: The mailbox control word at address 0x04 reads as {VERSION[3:0], 26 zero bits, core-flag at bit 1, host-flag at bit 0}. Writes to address 0x04 are ignored.
- R6: A read request to address 0x05 returns the word that the core posted, and it clears the host-flag. A read request to address 0x04 changes no state.
- R7: A host write to address 0x05 stores the word on `core_rdata` and sets the core-flag. A `core_rd` pulse clears the core-flag, but a host write in the same cycle wins.
- R8: A `core_wr` pulse stores `core_wdata` as the word for the host and sets the host-flag. A read of address 0x05 in the same cycle does not clear the flag.
- R9: Debug control (address 0x00) is 6 bits wide and debug status (address 0x01) is 5 bits wide. Their upper bits read as zero, and writes to those upper bits are dropped.
- R10: The vector-catch register at address 0x02 is 8 bits wide. When `HAS_VCATCH` = 0 the register is absent, and address 0x02 reads as zero.
- R11: Any address without a register (for example 0x03 or 0x0E) reads as zero, and writes to it leave every register unchanged.
- R12: While `trst_n` is low at a clock edge, every register, both flags, both mailbox words, the pending read word and the frame are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the only clock |
| trst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data in |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| tdo | output | 1 | Serial data out (frame bit 0) |
| core_wr | input | 1 | Core posts a word to the host |
| core_wdata | input | 32 | Word posted by the core |
| core_rd | input | 1 | Core has taken the host's word |
| core_rdata | output | 32 | Word last written by the host |
| comms_to_host | output | 1 | Host-flag: a core word is waiting |
| comms_to_core | output | 1 | Core-flag: a host word is waiting |
| dbg_ctrl_o | output | 6 | Debug control register |
| dbg_stat_o | output | 5 | Debug status register |
| vcatch_o | output | 8 | Vector-catch register |
| watch_o | output | 384 | Twelve watch words, packed |

## Verification
The hardest situations to reach from the ports are those where a core-side strobe lands on the exact clock of an update. Two such collisions matter: a posted word arriving while the host reads the data address, and the core taking a word while the host writes a new one. The bench scan task accepts core strobes that it raises only during the update cycle, so both collisions happen on the same edge. Every read is checked through its follow-up scan, which uses the control address, and on every clock a queue-based model is compared with the serial output and all parallel outputs.

// File: rtl/dbgscan_pkg.sv
// Package: frame geometry and fixed register addresses of the debug scan register file.
package dbgscan_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int CHAIN_W   = DATA_W + ADDR_W + 1;
    localparam int WATCH_WPU = 6;

    localparam logic [ADDR_W-1:0] A_DCTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_DSTAT  = 5'h01;
    localparam logic [ADDR_W-1:0] A_VCATCH = 5'h02;
    localparam logic [ADDR_W-1:0] A_CCTRL  = 5'h04;
    localparam logic [ADDR_W-1:0] A_CDATA  = 5'h05;

    // Base address of watch unit u: 0x08, 0x10, ...
    function automatic logic [ADDR_W-1:0] watch_addr(input int u, input int i);
        return ADDR_W'((u + 1) * 8 + i);
    endfunction
endpackage

// File: rtl/dbgscan_chain.sv
// Module: 38-bit serial frame register.
// Captures a read word with a zeroed header and shifts toward bit 0.
// Assumes that capture and shift are never high in the same cycle.
module dbgscan_chain #(
    parameter int CHAIN_W = 38,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               shift,
    input  logic               sin,
    input  logic [DATA_W-1:0]  cap_word,
    output logic [CHAIN_W-1:0] frame,
    output logic               sout
);
    localparam int HDR_W = CHAIN_W - DATA_W;

    // Frame register: reset, capture or shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       frame <= '0;
        else if (capture) frame <= {{HDR_W{1'b0}}, cap_word};
        else if (shift)   frame <= {sin, frame[CHAIN_W-1:1]};
    end

    assign sout = frame[0];
endmodule

// File: rtl/dbgscan_comms.sv
// Module: two-way mailbox between the host scan side and the core.
// A set request always wins over a clear request in the same cycle.
// Assumes that the core strobes are synchronous to the test clock.
module dbgscan_comms #(
    parameter int         DATA_W  = 32,
    parameter logic [3:0] VERSION = 4'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              core_wr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_rd,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] to_host_word,
    output logic [DATA_W-1:0] to_core_word,
    output logic              to_host_flag,
    output logic              to_core_flag
);
    localparam int RSV_W = DATA_W - 4 - 2;

    // Host-to-core word and core-flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_core_word <= '0;
            to_core_flag <= 1'b0;
        end else if (host_wr) begin
            to_core_word <= host_wdata;
            to_core_flag <= 1'b1;
        end else if (core_rd) begin
            to_core_flag <= 1'b0;
        end
    end

    // Core-to-host word and host-flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_host_word <= '0;
            to_host_flag <= 1'b0;
        end else if (core_wr) begin
            to_host_word <= core_wdata;
            to_host_flag <= 1'b1;
        end else if (host_rd) begin
            to_host_flag <= 1'b0;
        end
    end

    // Read-only control word seen by the host.
    assign ctrl_word = {VERSION, {RSV_W{1'b0}}, to_core_flag, to_host_flag};
endmodule

// File: rtl/dbgscan_regs.sv
// Module: debug control/status, optional vector catch and the watch words.
// Decodes one write port and one read port; unmapped addresses read as zero.
module dbgscan_regs
    import dbgscan_pkg::*;
#(
    parameter int DCTRL_W    = 6,
    parameter int DSTAT_W    = 5,
    parameter bit HAS_VCATCH = 1'b1,
    parameter int VCATCH_W   = 8,
    parameter int NUM_WATCH  = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic [DCTRL_W-1:0]                  dctrl,
    output logic [DSTAT_W-1:0]                  dstat,
    output logic [VCATCH_W-1:0]                 vcatch,
    output logic [NUM_WATCH*WATCH_WPU*DATA_W-1:0] watch
);
    localparam int NWORDS = NUM_WATCH * WATCH_WPU;

    logic [DATA_W-1:0] wreg [NWORDS];

    // Debug control and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dctrl <= '0;
            dstat <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_DCTRL) dctrl <= wr_data[DCTRL_W-1:0];
            if (wr_addr == A_DSTAT) dstat <= wr_data[DSTAT_W-1:0];
        end
    end

    // Optional vector-catch register.
    generate
        if (HAS_VCATCH) begin : g_vcatch
            always_ff @(posedge clk) begin
                if (!rst_n)                          vcatch <= '0;
                else if (wr_en && wr_addr == A_VCATCH) vcatch <= wr_data[VCATCH_W-1:0];
            end
        end else begin : g_no_vcatch
            assign vcatch = '0;
        end
    endgenerate

    // Watch value and mask words of all units.
    always_ff @(posedge clk) begin
        for (int u = 0; u < NUM_WATCH; u++) begin
            for (int i = 0; i < WATCH_WPU; i++) begin
                if (!rst_n)
                    wreg[u*WATCH_WPU+i] <= '0;
                else if (wr_en && wr_addr == watch_addr(u, i))
                    wreg[u*WATCH_WPU+i] <= wr_data;
            end
        end
    end

    // Pack the watch words for the core.
    always_comb begin
        for (int k = 0; k < NWORDS; k++) watch[k*DATA_W +: DATA_W] = wreg[k];
    end

    // Read multiplexer, zero-extended.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DCTRL:  rd_data[DCTRL_W-1:0]  = dctrl;
            A_DSTAT:  rd_data[DSTAT_W-1:0]  = dstat;
            A_VCATCH: rd_data[VCATCH_W-1:0] = vcatch;
            default: begin
                for (int u = 0; u < NUM_WATCH; u++)
                    for (int i = 0; i < WATCH_WPU; i++)
                        if (rd_addr == watch_addr(u, i)) rd_data = wreg[u*WATCH_WPU+i];
            end
        endcase
    end
endmodule

// File: rtl/dbgscan_top.sv
// Module: debug register file reached through a 38-bit scan frame.
// Writes act at update; reads latch a pending word that the next capture returns.
// Assumes that the strobes come from an external port controller, one per cycle.
module dbgscan_top
    import dbgscan_pkg::*;
#(
    parameter logic [3:0] VERSION    = 4'h6,
    parameter bit         HAS_VCATCH = 1'b1,
    parameter int         VCATCH_W   = 8,
    parameter int         NUM_WATCH  = 2,
    parameter int         DCTRL_W    = 6,
    parameter int         DSTAT_W    = 5
) (
    input  logic                                  tck,
    input  logic                                  trst_n,
    input  logic                                  tdi,
    input  logic                                  capture_en,
    input  logic                                  shift_en,
    input  logic                                  update_en,
    output logic                                  tdo,
    input  logic                                  core_wr,
    input  logic [31:0]                           core_wdata,
    input  logic                                  core_rd,
    output logic [31:0]                           core_rdata,
    output logic                                  comms_to_host,
    output logic                                  comms_to_core,
    output logic [DCTRL_W-1:0]                    dbg_ctrl_o,
    output logic [DSTAT_W-1:0]                    dbg_stat_o,
    output logic [VCATCH_W-1:0]                   vcatch_o,
    output logic [NUM_WATCH*WATCH_WPU*DATA_W-1:0] watch_o
);
    logic [CHAIN_W-1:0] chain_sr;
    logic [DATA_W-1:0]  pending_q, reg_rd, rd_word, ctrl_word, to_host_word;
    logic [ADDR_W-1:0]  f_addr;
    logic [DATA_W-1:0]  f_data;
    logic               f_write, scan_wr, scan_rd;

    assign f_data  = chain_sr[DATA_W-1:0];
    assign f_addr  = chain_sr[DATA_W +: ADDR_W];
    assign f_write = chain_sr[CHAIN_W-1];
    assign scan_wr = update_en &  f_write;
    assign scan_rd = update_en & ~f_write;

    dbgscan_chain #(.CHAIN_W(CHAIN_W), .DATA_W(DATA_W)) u_chain (
        .clk(tck), .rst_n(trst_n), .capture(capture_en), .shift(shift_en),
        .sin(tdi), .cap_word(pending_q), .frame(chain_sr), .sout(tdo)
    );

    dbgscan_regs #(
        .DCTRL_W(DCTRL_W), .DSTAT_W(DSTAT_W), .HAS_VCATCH(HAS_VCATCH),
        .VCATCH_W(VCATCH_W), .NUM_WATCH(NUM_WATCH)
    ) u_regs (
        .clk(tck), .rst_n(trst_n), .wr_en(scan_wr), .wr_addr(f_addr),
        .wr_data(f_data), .rd_addr(f_addr), .rd_data(reg_rd),
        .dctrl(dbg_ctrl_o), .dstat(dbg_stat_o), .vcatch(vcatch_o), .watch(watch_o)
    );

    dbgscan_comms #(.DATA_W(DATA_W), .VERSION(VERSION)) u_comms (
        .clk(tck), .rst_n(trst_n),
        .host_wr(scan_wr && f_addr == A_CDATA), .host_rd(scan_rd && f_addr == A_CDATA),
        .host_wdata(f_data), .core_wr(core_wr), .core_wdata(core_wdata), .core_rd(core_rd),
        .ctrl_word(ctrl_word), .to_host_word(to_host_word), .to_core_word(core_rdata),
        .to_host_flag(comms_to_host), .to_core_flag(comms_to_core)
    );

    // Select the word that a read request returns.
    always_comb begin
        case (f_addr)
            A_CCTRL: rd_word = ctrl_word;
            A_CDATA: rd_word = to_host_word;
            default: rd_word = reg_rd;
        endcase
    end

    // Pending read word, returned by the next capture.
    always_ff @(posedge tck) begin
        if (!trst_n)      pending_q <= '0;
        else if (scan_rd) pending_q <= rd_word;
    end
endmodule

// File: rtl/dbgscan_checker.sv
// Module: temporal checks on the scan register file, bound to the top module.
module dbgscan_checker #(
    parameter int CHAIN_W = 38,
    parameter int DCTRL_W = 6
) (
    input logic               tck,
    input logic               trst_n,
    input logic               capture_en,
    input logic               update_en,
    input logic               core_wr,
    input logic               core_rd,
    input logic [CHAIN_W-1:0] chain_sr,
    input logic               comms_to_host,
    input logic               comms_to_core,
    input logic [DCTRL_W-1:0] dbg_ctrl_o
);
    logic       f_write;
    logic [4:0] f_addr;
    assign f_write = chain_sr[CHAIN_W-1];
    assign f_addr  = chain_sr[CHAIN_W-2 -: 5];

    a_r2_capture_header: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en |=> chain_sr[CHAIN_W-1:CHAIN_W-6] == '0);

    a_r3_hold_without_update: assert property (@(posedge tck) disable iff (!trst_n)
        !update_en |=> $stable(dbg_ctrl_o));

    a_r6_data_read_clears: assert property (@(posedge tck) disable iff (!trst_n)
        (update_en && !f_write && f_addr == 5'h05 && !core_wr) |=> !comms_to_host);

    a_r7_host_write_sets: assert property (@(posedge tck) disable iff (!trst_n)
        (update_en && f_write && f_addr == 5'h05) |=> comms_to_core);

    a_r7_core_read_clears: assert property (@(posedge tck) disable iff (!trst_n)
        (core_rd && !(update_en && f_write && f_addr == 5'h05)) |=> !comms_to_core);

    a_r8_core_write_sets: assert property (@(posedge tck) disable iff (!trst_n)
        core_wr |=> comms_to_host);
endmodule

bind dbgscan_top dbgscan_checker #(.CHAIN_W(dbgscan_pkg::CHAIN_W), .DCTRL_W(DCTRL_W)) u_chk (
    .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .update_en(update_en),
    .core_wr(core_wr), .core_rd(core_rd), .chain_sr(chain_sr),
    .comms_to_host(comms_to_host), .comms_to_core(comms_to_core), .dbg_ctrl_o(dbg_ctrl_o)
);

// File: tb/dbgscan_top_tb.sv
// Bench: behavioural queue model compared on every clock, plus directed read-back checks.
module dbgscan_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] VER = 4'h6;

    logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
    logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic core_wr = 1'b0, core_rd = 1'b0;
    logic [31:0] core_wdata = '0;
    logic tdo, tdo_nv, c2h, c2c, c2h_nv, c2c_nv;
    logic [31:0] core_rdata, core_rdata_nv;
    logic [5:0] dctrl, dctrl_nv;
    logic [4:0] dstat, dstat_nv;
    logic [7:0] vc, vc_nv;
    logic [383:0] watch, watch_nv;

    int vectors = 0, fails = 0;

    always #(CLK_PERIOD/2) tck = ~tck;

    dbgscan_top u_dut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdo(tdo), .core_wr(core_wr), .core_wdata(core_wdata),
        .core_rd(core_rd), .core_rdata(core_rdata), .comms_to_host(c2h), .comms_to_core(c2c),
        .dbg_ctrl_o(dctrl), .dbg_stat_o(dstat), .vcatch_o(vc), .watch_o(watch)
    );

    dbgscan_top #(.HAS_VCATCH(1'b0)) u_dut_nv (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdo(tdo_nv), .core_wr(core_wr), .core_wdata(core_wdata),
        .core_rd(core_rd), .core_rdata(core_rdata_nv), .comms_to_host(c2h_nv), .comms_to_core(c2c_nv),
        .dbg_ctrl_o(dctrl_nv), .dbg_stat_o(dstat_nv), .vcatch_o(vc_nv), .watch_o(watch_nv)
    );

    // Reference model state
    bit          mq[$];
    logic [5:0]  m_dctrl;
    logic [4:0]  m_dstat;
    logic [7:0]  m_vc;
    logic [31:0] m_w[12];
    logic [31:0] m_h2c, m_c2h, m_pend;
    bit          m_fh, m_fc;

    function automatic logic [31:0] m_read(int a);
        if (a == 0) return {26'b0, m_dctrl};
        if (a == 1) return {27'b0, m_dstat};
        if (a == 2) return {24'b0, m_vc};
        if (a == 4) return {VER, 26'b0, m_fc, m_fh};
        if (a == 5) return m_c2h;
        if (a >= 8  && a <= 13) return m_w[a-8];
        if (a >= 16 && a <= 21) return m_w[a-16+6];
        return 32'h0;
    endfunction

    task automatic model_step();
        logic [31:0] d; int a; bit rw, hwr5, hrd5;
        if (!trst_n) begin
            mq.delete(); repeat (38) mq.push_back(1'b0);
            m_dctrl = 0; m_dstat = 0; m_vc = 0; m_h2c = 0; m_c2h = 0; m_pend = 0;
            m_fh = 0; m_fc = 0;
            foreach (m_w[k]) m_w[k] = 0;
            return;
        end
        hwr5 = 0; hrd5 = 0;
        if (update_en) begin
            d = 0; a = 0;
            for (int i = 0; i < 32; i++) d[i] = mq[i];
            for (int i = 0; i < 5; i++) a += int'(mq[32+i]) << i;
            rw = mq[37];
            if (rw) begin
                if (a == 0) m_dctrl = d[5:0];
                else if (a == 1) m_dstat = d[4:0];
                else if (a == 2) m_vc = d[7:0];
                else if (a == 5) begin m_h2c = d; hwr5 = 1; end
                else if (a >= 8 && a <= 13) m_w[a-8] = d;
                else if (a >= 16 && a <= 21) m_w[a-16+6] = d;
            end else begin
                m_pend = m_read(a);
                hrd5 = (a == 5);
            end
        end
        if (capture_en) begin
            mq.delete();
            for (int i = 0; i < 32; i++) mq.push_back(m_pend[i]);
            repeat (6) mq.push_back(1'b0);
        end else if (shift_en) begin
            void'(mq.pop_front()); mq.push_back(tdi);
        end
        if (core_wr) begin m_c2h = core_wdata; m_fh = 1; end
        else if (hrd5) m_fh = 0;
        if (hwr5) m_fc = 1;
        else if (core_rd) m_fc = 0;
    endtask

    task automatic cmp(string req, string what, logic [383:0] act, logic [383:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
            bad = 1;
        end
    endtask

    // One clock: model advances at the edge, outputs compared at the falling edge.
    task automatic tick();
        bit bad; logic [383:0] ew;
        @(posedge tck);
        model_step();
        @(negedge tck);
        bad = 0;
        for (int k = 0; k < 12; k++) ew[k*32 +: 32] = m_w[k];
        cmp("R1", "tdo", 384'(tdo), 384'(mq[0]), bad);
        cmp("R9", "dbg_ctrl", 384'(dctrl), 384'(m_dctrl), bad);
        cmp("R9", "dbg_stat", 384'(dstat), 384'(m_dstat), bad);
        cmp("R10", "vcatch", 384'(vc), 384'(m_vc), bad);
        cmp("R3", "watch", watch, ew, bad);
        cmp("R7", "core_rdata", 384'(core_rdata), 384'(m_h2c), bad);
        cmp("R8", "to_host flag", 384'(c2h), 384'(m_fh), bad);
        cmp("R7", "to_core flag", 384'(c2c), 384'(m_fc), bad);
        vectors++;
        if (bad) fails++;
    endtask

    task automatic check(string req, logic [37:0] act, logic [37:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Full scan; optional core strobes are raised in the update cycle only.
    task automatic scan(input bit rw, input logic [4:0] a, input logic [31:0] d,
                        input bit cw, input bit cr, input logic [31:0] cwd,
                        output logic [37:0] q, output logic [37:0] qnv);
        capture_en = 1; tick(); capture_en = 0; shift_en = 1;
        for (int i = 0; i < 38; i++) begin
            tdi = (i < 32) ? d[i] : (i < 37) ? a[i-32] : rw;
            q[i] = tdo; qnv[i] = tdo_nv;
            tick();
        end
        shift_en = 0; tdi = 0; update_en = 1;
        core_wr = cw; core_rd = cr; core_wdata = cwd;
        tick();
        update_en = 0; core_wr = 0; core_rd = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        logic [37:0] q, qn;
        scan(1, a, d, 0, 0, 0, q, qn);
    endtask

    // Read request followed by a control-address scan that returns the value.
    task automatic rd(input logic [4:0] a, output logic [37:0] q, output logic [37:0] qn);
        logic [37:0] t, tn;
        scan(0, a, 0, 0, 0, 0, t, tn);
        scan(0, 5'h04, 0, 0, 0, 0, q, qn);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [37:0] q, qn;
        repeat (38) mq.push_back(1'b0);
        repeat (3) tick();
        trst_n = 1; tick();
        check("R12 reset ctrl", 38'(dctrl), 38'h0);
        check("R12 reset flags", 38'({c2h, c2c}), 38'h0);

        // R9 widths
        wr(5'h00, 32'hFFFF_FFFF);
        check("R3 ctrl visible", 38'(dctrl), 38'h3F);
        rd(5'h00, q, qn); check("R9 ctrl readback", q, 38'h3F);
        check("R2 header zero", 38'(q[37:32]), 38'h0);
        wr(5'h01, 32'hAAAA_AAAA);
        rd(5'h01, q, qn); check("R9 status readback", q, 38'h0A);

        // R3/R4 watch words
        wr(5'h08, 32'h1234_5678); wr(5'h0D, 32'hCAFE_F00D);
        wr(5'h10, 32'hDEAD_BEEF); wr(5'h15, 32'h0BAD_C0DE);
        rd(5'h0D, q, qn); check("R4 watch0 ctrl mask", q, 38'hCAFE_F00D);
        rd(5'h15, q, qn); check("R4 watch1 ctrl mask", q, 38'h0BAD_C0DE);
        check("R3 watch word 6 position", 38'(watch[6*32 +: 32]), 38'hDEAD_BEEF);

        // R11 unmapped
        wr(5'h0E, 32'hFFFF_FFFF); wr(5'h03, 32'hFFFF_FFFF);
        rd(5'h0E, q, qn); check("R11 unmapped 0x0E", q, 38'h0);
        rd(5'h03, q, qn); check("R11 unmapped 0x03", q, 38'h0);

        // R10 vector catch
        wr(5'h02, 32'h0000_01FF);
        rd(5'h02, q, qn);
        check("R10 vcatch present", q, 38'hFF);
        check("R10 vcatch absent", qn, 38'h0);

        // R5 control word
        rd(5'h04, q, qn); check("R5 ctrl idle", q, 38'h6000_0000);
        wr(5'h04, 32'h0000_000F);
        rd(5'h04, q, qn); check("R5 ctrl write ignored", q, 38'h6000_0000);

        // R7 host to core
        wr(5'h05, 32'h1122_3344);
        check("R7 core_rdata", 38'(core_rdata), 38'h1122_3344);
        rd(5'h04, q, qn); check("R7 ctrl core-flag", q, 38'h6000_0002);
        core_rd = 1; tick(); core_rd = 0; tick();
        check("R7 core_rd clears", 38'(c2c), 38'h0);

        // R8 core to host; R6 control read harmless, data read destructive
        core_wr = 1; core_wdata = 32'hA5A5_A5A5; tick(); core_wr = 0; tick();
        check("R8 host-flag set", 38'(c2h), 38'h1);
        rd(5'h04, q, qn); check("R6 ctrl read 1", q, 38'h6000_0001);
        rd(5'h04, q, qn); check("R6 ctrl read 2", q, 38'h6000_0001);
        rd(5'h05, q, qn); check("R6 data value", q, 38'hA5A5_A5A5);
        check("R6 host-flag cleared", 38'(c2h), 38'h0);

        // R8 set wins over data read in the same cycle
        scan(0, 5'h05, 0, 1, 0, 32'h5A5A_0001, q, qn);
        check("R8 set wins over read", 38'(c2h), 38'h1);
        scan(0, 5'h04, 0, 0, 0, 0, q, qn);
        check("R6 old word returned", q, 38'hA5A5_A5A5);
        // R7 host write wins over core_rd in the same cycle
        scan(1, 5'h05, 32'h0F0F_0F0F, 0, 1, 0, q, qn);
        check("R7 set wins over core_rd", 38'(c2c), 38'h1);

        // R12 reset mid-run
        trst_n = 0; tick(); tick(); trst_n = 1; tick();
        check("R12 ctrl cleared", 38'(dctrl), 38'h0);
        check("R12 watch cleared", 38'(watch[5*32 +: 32]), 38'h0);
        check("R12 flags cleared", 38'({c2h, c2c}), 38'h0);
        rd(5'h0D, q, qn); check("R12 readback zero", q, 38'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule